// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is a master-mode serial port that moves 8-bit words over a three-wire link: a transfer clock it generates itself, a serial data output and a serial data input. Every frame is full duplex. The bits of the transmit word go out on one clock edge, and the bits on the input line are taken in on the opposite edge. After the eighth sampled bit the received word is ready for the consumer. The transfer clock is made from the system clock by a programmable divider. Each half period of the transfer clock lasts a set number of system cycles.

Software-facing controls are plain level inputs:
- a 3-bit mode field that either switches the port off or selects clock-synchronous operation;
- separate transmit and receive enables;
- a clock-polarity select that sets the idle clock level and both data edges together;
- a bit-order select;
- a data-inversion select.

Transmit words come in through a one-entry buffer with a valid/ready handshake. `tx_ready_o` is high only while the port is in clock-synchronous mode and the buffer is empty. A producer holds `tx_valid_i` and `tx_data_i` until it sees ready at a clock edge.

Received words leave through a one-entry holding register with valid/ready. `rx_valid_o` stays high and `rx_data_o` stays stable until `rx_ready_i` is sampled high. The link clock cannot be stalled, so back-pressure on the receive side does not stop the link. If another frame completes while a word is still held, the held word is overwritten and a sticky overrun flag is raised.

To recover from a communication error, the mode field is written to off and then back to clock-synchronous. This clears both buffers and the overrun flag.

Top module: `sync_serial_xcvr`

## Requirements
- R1: With `clk_pol_i`=0 the clock output rests high while idle. Output data changes on its falling edges, and input data is sampled on its rising edges.
- R2: With `clk_pol_i`=1 the clock output rests low while idle. Output data changes on its rising edges, and input data is sampled on its falling edges.
- R3: A frame carries 8 data bits. With `msb_first_i`=0, bit 0 of the word is the first bit on the wire, both when sending and when receiving.
- R4: With `msb_first_i`=1, bit 7 is the first bit on the wire in both directions.
- R5: With `invert_i`=1, every transmitted bit is the complement of the word bit, and every received word bit is the complement of the sampled wire bit. With `invert_i`=0, data passes unchanged.
- R6: Only mode code 3'b001 operates the port. Any other code (3'b000 means off) holds `tx_ready_o` low, keeps the clock at its idle level and leaves the data output high.
- R7: Each half period of the transfer clock lasts `div_i`+1 system clock cycles. Consecutive sample edges are therefore 2*(`div_i`+1) cycles apart.
- R8: A frame starts only when `tx_en_i` is 1, the mode is 3'b001 and the transmit buffer holds a word. While `tx_en_i` is 0, a full buffer produces no clock edges.
- R9: The transmit buffer accepts a word on a clock edge where `tx_valid_i` and `tx_ready_o` are both high. `tx_empty_o` goes high when the buffered word moves into the shift register, which frees the buffer for the next word.
- R10: `rx_valid_o` rises after the eighth sampled bit of a frame, but only when `rx_en_i` is 1. It then holds, with `rx_data_o` stable, until `rx_ready_i` is sampled high.
- R11: `overrun_o` is set when a frame completes while `rx_valid_o` is still high and is not being taken in that cycle. Once set it stays set while the mode stays 3'b001.
- R12: Writing the mode to a code other than 3'b001 and then back to 3'b001 leaves the transmit buffer empty, `rx_valid_o` low and `overrun_o` low. A word buffered before the sequence is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Mode field: 3'b001 clock-synchronous, 3'b000 off, other codes also off |
| tx_en_i | input | 1 | Transmit enable (gates frame start) |
| rx_en_i | input | 1 | Receive enable (gates storing of received words) |
| clk_pol_i | input | 1 | Clock polarity: 0 idle high/launch on fall, 1 idle low/launch on rise |
| msb_first_i | input | 1 | Bit order: 0 bit 0 first, 1 bit 7 first |
| invert_i | input | 1 | Complement data on both paths |
| div_i | input | DIV_W | Half period of transfer clock minus one, in system cycles |
| tx_valid_i | input | 1 | Transmit word valid |
| tx_data_i | input | DATA_W | Transmit word |
| tx_ready_o | output | 1 | Transmit buffer can accept a word |
| tx_empty_o | output | 1 | Transmit buffer holds no word |
| rx_valid_o | output | 1 | Received word available (receive-complete flag) |
| rx_data_o | output | DATA_W | Received word |
| rx_ready_i | input | 1 | Consumer takes the received word |
| overrun_o | output | 1 | Sticky receive overrun flag |
| sck_o | output | 1 | Transfer clock output |
| sdo_o | output | 1 | Serial data output |
| sdi_i | input | 1 | Serial data input |

## Verification
The hardest state to reach from the ports is a full transmit buffer that must be dropped. In that state a recovery sequence has to discard a word that would otherwise go out on the link. The bench gets there by clearing the transmit enable before it pushes a word, so the word stays parked in the buffer. It then toggles the mode off and back on, restores the enable, and counts clock edges over a long window to show that nothing was sent. Overrun is reached in a similar way: the consumer withholds ready while two words are pushed back to back, and the second push only succeeds once the first word has moved into the shifter.

// File: rtl/ssio_pkg.sv
`timescale 1ns/1ps
package ssio_pkg;
  localparam int unsigned MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_SYNC = 3'b001;

  // Word formatting applied between the parallel word and the wire order
  typedef struct packed {
    logic msb_first;
    logic invert;
  } ssio_fmt_t;
endpackage

// File: rtl/ssio_order.sv
`timescale 1ns/1ps
// Maps a word to or from wire order: optional reversal, then optional complement.
// Both steps commute, so the same unit serves the transmit and the receive path.
module ssio_order
  import ssio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] d_i,
  input  ssio_fmt_t    fmt_i,
  output logic [W-1:0] d_o
);
  logic [W-1:0] rev;

  for (genvar g = 0; g < W; g++) begin : g_rev
    assign rev[g] = d_i[W-1-g];
  end

  assign d_o = (fmt_i.msb_first ? rev : d_i) ^ {W{fmt_i.invert}};
endmodule

// File: rtl/ssio_halfclk.sv
`timescale 1ns/1ps
// Half-period timer: pulses tick_o on the last system cycle of each half period.
module ssio_halfclk #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt;

  assign tick_o = run_i && (cnt == div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run_i || tick_o) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ssio_tx.sv
`timescale 1ns/1ps
// One-entry transmit buffer plus shift register holding the word in wire order.
module ssio_tx
  import ssio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  ssio_fmt_t    fmt_i,
  input  logic         tx_valid_i,
  input  logic [W-1:0] tx_data_i,
  output logic         tx_ready_o,
  output logic         full_o,
  input  logic         load_i,
  input  logic         shift_i,
  output logic         bit_o
);
  logic [W-1:0] buf_q;
  logic [W-1:0] sr_q;
  logic [W-1:0] wire_word;
  logic         full_q;

  ssio_order #(.W(W)) u_ord (
    .d_i  (buf_q),
    .fmt_i(fmt_i),
    .d_o  (wire_word)
  );

  assign tx_ready_o = !clr_i && !full_q;
  assign full_o     = full_q;
  assign bit_o      = sr_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      sr_q   <= '0;
      full_q <= 1'b0;
    end else if (clr_i) begin
      full_q <= 1'b0;
    end else begin
      if (load_i) begin
        sr_q   <= wire_word;
        full_q <= 1'b0;
      end else if (tx_valid_i && !full_q) begin
        buf_q  <= tx_data_i;
        full_q <= 1'b1;
      end
      if (shift_i) begin
        sr_q <= sr_q >> 1;
      end
    end
  end
endmodule

// File: rtl/ssio_rx.sv
`timescale 1ns/1ps
// Receive shifter, one-entry holding register and sticky overrun flag.
module ssio_rx
  import ssio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  ssio_fmt_t    fmt_i,
  input  logic         rx_en_i,
  input  logic         sample_i,
  input  logic         last_i,
  input  logic         sdi_i,
  input  logic         rx_ready_i,
  output logic         rx_valid_o,
  output logic [W-1:0] rx_data_o,
  output logic         overrun_o
);
  logic [W-1:0] sr_q;
  logic [W-1:0] wire_word;
  logic [W-1:0] word;
  logic         valid_q;
  logic         ovr_q;

  // First wire bit ends up in bit 0 after W samples
  assign wire_word = {sdi_i, sr_q[W-1:1]};

  ssio_order #(.W(W)) u_ord (
    .d_i  (wire_word),
    .fmt_i(fmt_i),
    .d_o  (word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q      <= '0;
      rx_data_o <= '0;
      valid_q   <= 1'b0;
      ovr_q     <= 1'b0;
    end else if (clr_i) begin
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (sample_i) begin
        sr_q <= wire_word;
      end
      if (last_i && rx_en_i) begin
        rx_data_o <= word;
        valid_q   <= 1'b1;
        if (valid_q && !rx_ready_i) begin
          ovr_q <= 1'b1;
        end
      end else if (valid_q && rx_ready_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign rx_valid_o = valid_q;
  assign overrun_o  = ovr_q;
endmodule

// File: rtl/sync_serial_xcvr.sv
`timescale 1ns/1ps
module sync_serial_xcvr
  import ssio_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic              clk_pol_i,
  input  logic              msb_first_i,
  input  logic              invert_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  output logic              tx_empty_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  input  logic              rx_ready_i,
  output logic              overrun_o,
  output logic              sck_o,
  output logic              sdo_o,
  input  logic              sdi_i
);
  localparam int unsigned PH_N = 2 * DATA_W;
  localparam int unsigned PH_W = $clog2(PH_N);
  localparam logic [PH_W-1:0] PH_END  = PH_W'(PH_N - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PH_N - 2);

  ssio_fmt_t       fmt;
  logic            en;
  logic            busy;
  logic [PH_W-1:0] ph;
  logic            tick;
  logic            tx_full;
  logic            tx_bit;
  logic            start;
  logic            sample;
  logic            last_sample;
  logic            shift;

  assign fmt.msb_first = msb_first_i;
  assign fmt.invert    = invert_i;
  assign en            = (mode_i == MODE_SYNC);

  assign start       = en && !busy && tx_en_i && tx_full;
  assign sample      = tick && !ph[0];
  assign last_sample = sample && (ph == PH_LAST);
  assign shift       = tick && ph[0] && (ph != PH_END);

  // Frame sequencer: even phases sit at the launch level, odd at the sample level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ph   <= '0;
    end else if (!en) begin
      busy <= 1'b0;
      ph   <= '0;
    end else if (start) begin
      busy <= 1'b1;
      ph   <= '0;
    end else if (tick) begin
      ph <= ph + 1'b1;
      if (ph == PH_END) begin
        busy <= 1'b0;
      end
    end
  end

  ssio_halfclk #(.DIV_W(DIV_W)) u_halfclk (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (busy),
    .div_i (div_i),
    .tick_o(tick)
  );

  ssio_tx #(.W(DATA_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (!en),
    .fmt_i     (fmt),
    .tx_valid_i(tx_valid_i),
    .tx_data_i (tx_data_i),
    .tx_ready_o(tx_ready_o),
    .full_o    (tx_full),
    .load_i    (start),
    .shift_i   (shift),
    .bit_o     (tx_bit)
  );

  ssio_rx #(.W(DATA_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (!en),
    .fmt_i     (fmt),
    .rx_en_i   (rx_en_i),
    .sample_i  (sample),
    .last_i    (last_sample),
    .sdi_i     (sdi_i),
    .rx_ready_i(rx_ready_i),
    .rx_valid_o(rx_valid_o),
    .rx_data_o (rx_data_o),
    .overrun_o (overrun_o)
  );

  assign tx_empty_o = !tx_full;
  assign sck_o      = busy ? (ph[0] ^ clk_pol_i) : ~clk_pol_i;
  assign sdo_o      = busy ? tx_bit : 1'b1;
endmodule

// File: rtl/sync_serial_xcvr_chk.sv
`timescale 1ns/1ps
module sync_serial_xcvr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_i,
  input logic       clk_pol_i,
  input logic       rx_en_i,
  input logic       rx_ready_i,
  input logic       tx_empty_o,
  input logic       rx_valid_o,
  input logic       overrun_o,
  input logic       sck_o,
  input logic       sdo_o,
  input logic       busy
);
  // R12
  recovery_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 3'b001) |=> (tx_empty_o && !rx_valid_o && !overrun_o && !busy));

  // R1
  idle_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $stable(clk_pol_i)) |-> $stable(sck_o));

  // R2
  launch_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $stable(clk_pol_i) && !$stable(sdo_o)) |-> (sck_o == clk_pol_i));

  // R11
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_o) |-> $past(rx_valid_o));

  // R10
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid_o) |-> $past(rx_en_i));

  // R10
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i && mode_i == 3'b001) |=> rx_valid_o);
endmodule

bind sync_serial_xcvr sync_serial_xcvr_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_i    (mode_i),
  .clk_pol_i (clk_pol_i),
  .rx_en_i   (rx_en_i),
  .rx_ready_i(rx_ready_i),
  .tx_empty_o(tx_empty_o),
  .rx_valid_o(rx_valid_o),
  .overrun_o (overrun_o),
  .sck_o     (sck_o),
  .sdo_o     (sdo_o),
  .busy      (busy)
);

// File: tb/sync_serial_xcvr_bench.sv
`timescale 1ns/1ps
module sync_serial_xcvr_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'b000;
  logic       tx_en = 1'b0, rx_en = 1'b0, clk_pol = 1'b0, msb = 1'b0, inv = 1'b0;
  logic [7:0] div = 8'd0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'd0;
  logic       rx_ready = 1'b0;
  logic       sdi = 1'b1;
  logic       tx_ready, tx_empty, rx_valid, overrun, sck, sdo;
  logic [7:0] rx_data;

  always #2.5 clk = ~clk;

  sync_serial_xcvr u_sync_serial_xcvr (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .tx_en_i(tx_en), .rx_en_i(rx_en),
    .clk_pol_i(clk_pol), .msb_first_i(msb), .invert_i(inv), .div_i(div),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready),
    .tx_empty_o(tx_empty), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .rx_ready_i(rx_ready), .overrun_o(overrun), .sck_o(sck), .sdo_o(sdo), .sdi_i(sdi)
  );

  int    n_chk = 0, n_fail = 0, cyc = 0;
  bit    done = 0;
  string cur_req = "R6";
  logic [7:0] pat = 8'h00;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [7:0] rev8(logic [7:0] d);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = d[7-k];
    return r;
  endfunction

  function automatic logic [7:0] fmt8(logic [7:0] d);
    return (msb ? rev8(d) : d) ^ {8{inv}};
  endfunction

  // Behavioural reference model
  int         m_busy = 0, m_half = 0, m_cnt = 0, m_rxv = 0, m_ovr = 0;
  logic [7:0] m_word = 0, m_rxd = 0, m_bits = 0;
  logic [7:0] m_txq[$];

  always @(posedge clk) begin
    bit pop, setv, fullb;
    if (!rst_n || mode != 3'b001) begin
      m_busy = 0; m_rxv = 0; m_ovr = 0; m_cnt = 0; m_half = 0;
      m_txq.delete();
    end else begin
      pop = (m_rxv != 0) && rx_ready;
      setv = 0;
      fullb = (m_txq.size() != 0);
      if (m_busy == 0) begin
        if (tx_en && fullb) begin
          m_busy = 1; m_half = 0; m_cnt = 0;
          m_word = fmt8(m_txq.pop_front());
        end
      end else if (m_cnt == int'(div)) begin
        m_cnt = 0;
        if (m_half % 2 == 0) begin
          m_bits[m_half/2] = sdi;
          if (m_half == 14 && rx_en) begin
            if (m_rxv != 0 && !pop) m_ovr = 1;
            m_rxd = fmt8(m_bits);
            m_rxv = 1;
            setv = 1;
          end
        end
        if (m_half == 15) m_busy = 0;
        m_half++;
      end else begin
        m_cnt++;
      end
      if (pop && !setv) m_rxv = 0;
      if (tx_valid && !fullb) m_txq.push_back(tx_data);
    end
  end

  // Input line pattern, changed away from the active edge
  always @(negedge clk) sdi <= (m_busy != 0) ? pat[m_half/2] : 1'b1;

  // Sample-edge monitor: captures output bits on the wire independently of the model
  logic [7:0] cap = 0;
  int         edge_n = 0, first_cyc = 0, last_cyc = 0;
  logic       prev_sck = 1'b1;

  task automatic clear_mon();
    edge_n = 0; cap = 0;
  endtask

  always @(posedge clk) begin
    #1;
    cyc++;
    if (rst_n) begin
      chk(cur_req, "sck", sck, (m_busy != 0) ? ((m_half % 2 != 0) ^ clk_pol) : !clk_pol);
      chk(cur_req, "sdo", sdo, (m_busy != 0) ? m_word[m_half/2] : 1'b1);
      chk(cur_req, "tx_ready", tx_ready, (mode == 3'b001) && (m_txq.size() == 0));
      chk(cur_req, "rx_valid", rx_valid, m_rxv != 0);
      chk(cur_req, "overrun", overrun, m_ovr != 0);
      if (m_rxv != 0) chk(cur_req, "rx_data", rx_data, m_rxd);
      if (prev_sck == clk_pol && sck == !clk_pol) begin
        if (edge_n < 8) cap[edge_n] = sdo;
        if (edge_n == 0) first_cyc = cyc;
        last_cyc = cyc;
        edge_n++;
      end
    end
    prev_sck = sck;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      finish_run();
    end
  end

  task automatic push(logic [7:0] d);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = d;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop_rx();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic wait_frame();
    repeat (16 * (int'(div) + 1) + 6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R6", "tx_ready off", tx_ready, 0);
    chk("R1", "idle sck", sck, 1);
    chk("R9", "tx_empty", tx_empty, 1);
    chk("R10", "rx_valid", rx_valid, 0);

    // R3 / R1 / R7: LSB first, polarity 0, div 1
    cur_req = "R3";
    mode = 3'b001; tx_en = 1; rx_en = 1; div = 8'd1; pat = 8'h3C;
    @(negedge clk);
    chk("R6", "tx_ready on", tx_ready, 1);
    clear_mon();
    push(8'hA5);
    wait_frame();
    chk("R3", "wire bits", cap, 8'hA5);
    chk("R3", "rx word", rx_data, 8'h3C);
    chk("R7", "edge spacing", last_cyc - first_cyc, 7 * 2 * 2);
    chk("R1", "idle high", sck, 1);
    pop_rx();

    // R4 / R2: MSB first, polarity 1, div 0
    cur_req = "R4";
    clk_pol = 1; msb = 1; div = 8'd0; pat = 8'h1E;
    @(negedge clk);
    chk("R2", "idle low", sck, 0);
    clear_mon();
    push(8'hC4);
    wait_frame();
    chk("R4", "wire bits", cap, 8'h23);
    chk("R4", "rx word", rx_data, 8'h78);
    chk("R2", "edges", edge_n, 8);
    chk("R7", "edge spacing", last_cyc - first_cyc, 7 * 2 * 1);
    pop_rx();

    // R5: inversion, polarity 0, LSB first, div 2
    cur_req = "R5";
    clk_pol = 0; msb = 0; inv = 1; div = 8'd2; pat = 8'h0F;
    @(negedge clk);
    clear_mon();
    push(8'h5A);
    wait_frame();
    chk("R5", "wire bits", cap, 8'hA5);
    chk("R5", "rx word", rx_data, 8'hF0);
    pop_rx();
    inv = 0; div = 8'd1;

    // R8 / R9: transmit disabled holds the word in the buffer
    cur_req = "R8";
    tx_en = 0; pat = 8'h96;
    clear_mon();
    push(8'h11);
    repeat (60) @(negedge clk);
    chk("R8", "no edges", edge_n, 0);
    chk("R9", "tx_empty full", tx_empty, 0);
    tx_en = 1;
    repeat (3) @(negedge clk);
    chk("R9", "tx_empty after load", tx_empty, 1);
    wait_frame();
    chk("R8", "edges", edge_n, 8);
    chk("R8", "wire bits", cap, 8'h11);
    chk("R10", "rx held", rx_valid, 1);
    repeat (5) @(negedge clk);
    chk("R10", "rx still held", rx_data, 8'h96);
    pop_rx();

    // R11: back-to-back frames with no consumer
    cur_req = "R11";
    push(8'h01);
    push(8'h02);
    wait_frame();
    wait_frame();
    chk("R11", "overrun", overrun, 1);
    chk("R11", "rx_valid", rx_valid, 1);
    pop_rx();
    repeat (4) @(negedge clk);
    chk("R11", "overrun sticky", overrun, 1);

    // R12: recovery drops a parked word and clears flags
    cur_req = "R12";
    tx_en = 0;
    push(8'h77);
    @(negedge clk); mode = 3'b000;
    @(negedge clk); mode = 3'b001;
    @(negedge clk);
    chk("R12", "overrun", overrun, 0);
    chk("R12", "rx_valid", rx_valid, 0);
    chk("R12", "tx_empty", tx_empty, 1);
    chk("R12", "tx_ready", tx_ready, 1);
    clear_mon();
    tx_en = 1;
    repeat (60) @(negedge clk);
    chk("R12", "nothing sent", edge_n, 0);

    // R10: receive disabled
    cur_req = "R10";
    rx_en = 0;
    push(8'h33);
    wait_frame();
    chk("R10", "rx gated", rx_valid, 0);
    rx_en = 1;

    // R6: other mode codes
    cur_req = "R6";
    clear_mon();
    mode = 3'b010;
    tx_valid = 1; tx_data = 8'h44;
    repeat (40) @(negedge clk);
    chk("R6", "tx_ready", tx_ready, 0);
    chk("R6", "no edges", edge_n, 0);
    chk("R6", "sdo idle", sdo, 1);
    tx_valid = 0;
    mode = 3'b001;
    repeat (4) @(negedge clk);

    finish_run();
  end
endmodule